// File: doc/BRIEF.md
# Program Counter with Hardware Return Stack

This block is the fetch-side control of a small RISC core with one-word (16-bit) instructions and 512 words of program memory. It holds a 9-bit program counter and presents it to program memory every clock. The word that comes back is captured into an execute register, so the next word is fetched while the current one executes. In straight-line code this issues one instruction per clock.

The decoder that consumes the executing word drives four control strobes: relative jump, relative call, return and interrupt. It also drives a signed relative offset and an interrupt vector address. Any accepted transfer throws away the word already fetched behind it and costs one empty cycle while the pipeline refills. Return addresses live in a small dedicated hardware stack, three entries deep by default. The stack does not use data memory. It never reports a fault: a push onto a full stack loses the oldest entry, and a pop from an empty stack keeps returning the bottom value.

Top module: `pc_fetch_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0 and `exec_valid` is 0. On the first clock after release, the word at address 0 becomes the executing word.
- R2: When no transfer is accepted, each clock loads `fetch_data` into `exec_word`, loads `fetch_addr` into `exec_pc`, sets `exec_valid`, and advances `fetch_addr` by one modulo 512 (511 wraps to 0).
- R3: An accepted relative jump loads `fetch_addr` with (`exec_pc` + 1 + `rel_off`) modulo 512. Here `rel_off` is a 9-bit two's-complement value, so every address is reachable from every location.
- R4: An accepted relative call goes to the same target as R3 and pushes `exec_pc` + 1 as the return address.
- R5: An accepted return loads `fetch_addr` with the top stack entry and pops it.
- R6: An accepted interrupt loads `fetch_addr` with `irq_vec` and pushes `exec_pc`. The interrupted word is abandoned unexecuted, and a later return re-executes it.
- R7: When several strobes are high together, only one is acted on. Interrupt beats return, return beats call, and call beats jump.
- R8: In the clock after an accepted transfer, `exec_valid` is 0. In the clock after that, the word at the target is executing with `exec_valid` high.
- R9: The stack holds the three most recent return addresses, and pops return them newest first. A push onto a full stack discards the oldest entry.
- R10: A pop from an empty stack yields the bottom entry without fault, and repeated pops keep yielding it. Right after reset that value is 0.
- R11: All four strobes are ignored while `exec_valid` is 0. Fetch then proceeds as in R2 and the stack is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | 9 | Program-memory word address (the program counter) |
| fetch_data | input | 16 | Word read from program memory at `fetch_addr` in the same cycle |
| do_jump | input | 1 | Executing word is a relative jump |
| do_call | input | 1 | Executing word is a relative call |
| do_return | input | 1 | Executing word is a return |
| do_irq | input | 1 | Take an interrupt in place of the executing word |
| rel_off | input | 9 | Two's-complement relative offset for jump and call |
| irq_vec | input | 9 | Interrupt entry address |
| exec_word | output | 16 | Instruction word now executing |
| exec_pc | output | 9 | Address of the executing word |
| exec_valid | output | 1 | Executing word is real, not a refill bubble |

## Verification
A long straight-line run crosses address 511, which shows whether the counter wraps or sticks. A jump is issued with every one of the 512 offsets from a drifting base. This separates correct modulo arithmetic and sign handling from off-by-one link addresses, and it checks the refill bubble after each jump. Nested calls deeper than the stack, followed by extra returns, separate oldest-entry loss from newest-entry loss and show bottom retention. Returning from an empty stack after reset, and all fifteen mixes of simultaneous strobes, isolate the priority order. Strobes raised during a bubble show that they are ignored.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   // Kind of program-flow step chosen for the next fetch address.
   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_JUMP,
      FLOW_CALL,
      FLOW_RET,
      FLOW_IRQ
   } flow_e;

endpackage

// File: rtl/pcs_ret_stack.sv
// Dedicated return-address stack built as a shift register.
// A push moves every entry one place down, and the deepest entry falls off.
// A pop moves every entry one place up, and the deepest entry keeps its value.
module pcs_ret_stack #(
   parameter int          WIDTH     = 9,
   parameter int          DEPTH     = 3,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] push_val,
   output logic [WIDTH-1:0] top
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pcs_ret_stack: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] slot;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    slot <= RESET_VAL;
         else if (push) slot <= push_val;
      end
      assign top = slot;
   end else begin : g_shift
      logic [WIDTH-1:0] ent [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ent[k] <= RESET_VAL;
         end else if (push) begin
            ent[0] <= push_val;
            for (int k = 1; k < DEPTH; k++) ent[k] <= ent[k-1];
         end else if (pop) begin
            for (int k = 0; k < DEPTH-1; k++) ent[k] <= ent[k+1];
         end
      end
      assign top = ent[0];
   end

endmodule

// File: rtl/pcs_flow_ctl.sv
// Chooses the next fetch address and the stack action from the control strobes.
module pcs_flow_ctl
   import pcs_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              exec_valid,
   input  logic              do_jump,
   input  logic              do_call,
   input  logic              do_return,
   input  logic              do_irq,
   input  logic [ADDR_W-1:0] rel_off,
   input  logic [ADDR_W-1:0] irq_vec,
   input  logic [ADDR_W-1:0] exec_pc,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic [ADDR_W-1:0] stack_top,
   output logic [ADDR_W-1:0] next_pc,
   output logic              push,
   output logic              pop,
   output logic [ADDR_W-1:0] push_val,
   output logic              flush
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   flow_e             flow;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] link_pc;
   logic [ADDR_W-1:0] rel_pc;

   // Addition at ADDR_W bits wraps modulo the address space.
   assign seq_pc  = fetch_pc + ONE;
   assign link_pc = exec_pc + ONE;
   assign rel_pc  = link_pc + rel_off;

   always_comb begin
      flow = FLOW_SEQ;
      if (exec_valid) begin
         if      (do_irq)    flow = FLOW_IRQ;
         else if (do_return) flow = FLOW_RET;
         else if (do_call)   flow = FLOW_CALL;
         else if (do_jump)   flow = FLOW_JUMP;
      end
   end

   always_comb begin
      next_pc  = seq_pc;
      push     = 1'b0;
      pop      = 1'b0;
      push_val = link_pc;
      unique case (flow)
         FLOW_IRQ: begin
            next_pc  = irq_vec;
            push     = 1'b1;
            push_val = exec_pc;
         end
         FLOW_RET: begin
            next_pc = stack_top;
            pop     = 1'b1;
         end
         FLOW_CALL: begin
            next_pc = rel_pc;
            push    = 1'b1;
         end
         FLOW_JUMP: next_pc = rel_pc;
         default:   next_pc = seq_pc;
      endcase
   end

   assign flush = (flow != FLOW_SEQ);

endmodule

// File: rtl/pcs_fetch_reg.sv
// Execute-side register of the two-stage pipeline: holds the prefetched word.
module pcs_fetch_reg #(
   parameter int ADDR_W  = 9,
   parameter int INSTR_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [ADDR_W-1:0]  fetch_pc,
   input  logic [INSTR_W-1:0] fetch_word,
   output logic [INSTR_W-1:0] exec_word,
   output logic [ADDR_W-1:0]  exec_pc,
   output logic               exec_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exec_word  <= '0;
         exec_pc    <= '0;
         exec_valid <= 1'b0;
      end else if (flush) begin
         exec_valid <= 1'b0;
      end else begin
         exec_word  <= fetch_word;
         exec_pc    <= fetch_pc;
         exec_valid <= 1'b1;
      end
   end

endmodule

// File: rtl/pc_fetch_unit.sv
// Program counter, prefetch register and return stack.
module pc_fetch_unit #(
   parameter int ADDR_W      = 9,
   parameter int INSTR_W     = 16,
   parameter int STACK_DEPTH = 3,
   parameter int RESET_ADDR  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [ADDR_W-1:0]  fetch_addr,
   input  logic [INSTR_W-1:0] fetch_data,
   input  logic               do_jump,
   input  logic               do_call,
   input  logic               do_return,
   input  logic               do_irq,
   input  logic [ADDR_W-1:0]  rel_off,
   input  logic [ADDR_W-1:0]  irq_vec,
   output logic [INSTR_W-1:0] exec_word,
   output logic [ADDR_W-1:0]  exec_pc,
   output logic               exec_valid
);

   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(RESET_ADDR);

   if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr
      $error("pc_fetch_unit: ADDR_W out of range");
   end
   if (INSTR_W < 1) begin : g_bad_instr
      $error("pc_fetch_unit: INSTR_W must be positive");
   end
   if (STACK_DEPTH < 1) begin : g_bad_stack
      $error("pc_fetch_unit: STACK_DEPTH must be at least 1");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;
   logic [ADDR_W-1:0] stk_top;
   logic [ADDR_W-1:0] stk_val;
   logic              stk_push;
   logic              stk_pop;
   logic              flush;

   pcs_flow_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .exec_valid (exec_valid),
      .do_jump    (do_jump),
      .do_call    (do_call),
      .do_return  (do_return),
      .do_irq     (do_irq),
      .rel_off    (rel_off),
      .irq_vec    (irq_vec),
      .exec_pc    (exec_pc),
      .fetch_pc   (pc_q),
      .stack_top  (stk_top),
      .next_pc    (pc_d),
      .push       (stk_push),
      .pop        (stk_pop),
      .push_val   (stk_val),
      .flush      (flush)
   );

   pcs_ret_stack #(
      .WIDTH     (ADDR_W),
      .DEPTH     (STACK_DEPTH),
      .RESET_VAL ('0)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (stk_push),
      .pop      (stk_pop),
      .push_val (stk_val),
      .top      (stk_top)
   );

   pcs_fetch_reg #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_exec (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .fetch_pc   (pc_q),
      .fetch_word (fetch_data),
      .exec_word  (exec_word),
      .exec_pc    (exec_pc),
      .exec_valid (exec_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= PC_RST;
      else        pc_q <= pc_d;
   end

   assign fetch_addr = pc_q;

endmodule

// File: rtl/pcs_checks.sv
module pcs_checks #(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              do_jump,
   input logic              do_call,
   input logic              do_return,
   input logic              do_irq,
   input logic [ADDR_W-1:0] rel_off,
   input logic [ADDR_W-1:0] irq_vec,
   input logic [ADDR_W-1:0] exec_pc,
   input logic              exec_valid
);

   logic any_ctl;
   assign any_ctl = do_jump | do_call | do_return | do_irq;

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && !any_ctl) |=>
         (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)) && exec_valid
         && (exec_pc == $past(fetch_addr)));

   assert_ignore_in_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_valid |=>
         exec_valid && (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && any_ctl) |=> !exec_valid);

   assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && do_jump && !do_call && !do_return && !do_irq) |=>
         fetch_addr == ADDR_W'($past(exec_pc) + 1'b1 + $past(rel_off)));

   assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && do_call && !do_return && !do_irq) |=>
         fetch_addr == ADDR_W'($past(exec_pc) + 1'b1 + $past(rel_off)));

   assert_irq_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && do_irq) |=> fetch_addr == $past(irq_vec));

endmodule

bind pc_fetch_unit pcs_checks #(.ADDR_W(ADDR_W)) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .fetch_addr (fetch_addr),
   .do_jump    (do_jump),
   .do_call    (do_call),
   .do_return  (do_return),
   .do_irq     (do_irq),
   .rel_off    (rel_off),
   .irq_vec    (irq_vec),
   .exec_pc    (exec_pc),
   .exec_valid (exec_valid)
);

// File: tb/tb_pc_fetch_unit.sv
`timescale 1ns/1ps
module tb_pc_fetch_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  fetch_addr;
   logic [15:0] fetch_data;
   logic        do_jump = 1'b0, do_call = 1'b0, do_return = 1'b0, do_irq = 1'b0;
   logic [8:0]  rel_off = '0, irq_vec = '0;
   logic [15:0] exec_word;
   logic [8:0]  exec_pc;
   logic        exec_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   function automatic logic [15:0] mem_word(input logic [8:0] a);
      return {a[6:0], a} ^ 16'h5A3C;
   endfunction

   assign fetch_data = mem_word(fetch_addr);

   pc_fetch_unit dut (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .do_jump(do_jump), .do_call(do_call), .do_return(do_return), .do_irq(do_irq),
      .rel_off(rel_off), .irq_vec(irq_vec),
      .exec_word(exec_word), .exec_pc(exec_pc), .exec_valid(exec_valid)
   );

   // Reference state derived from the requirements.
   logic [8:0] m_pc = '0;
   logic [8:0] m_epc = '0;
   logic       m_val = 1'b0;
   logic [8:0] m_stk [3] = '{default: '0};

   task automatic m_push(input logic [8:0] v);
      m_stk[2] = m_stk[1];
      m_stk[1] = m_stk[0];
      m_stk[0] = v;
   endtask

   task automatic check(input string tag);
      n_chk++;
      if (exec_valid !== m_val || fetch_addr !== m_pc ||
          (m_val && (exec_pc !== m_epc || exec_word !== mem_word(m_epc)))) begin
         n_bad++;
         $display("FAIL %s: got valid=%0b pc=%h epc=%h word=%h, expected valid=%0b pc=%h epc=%h word=%h",
                  tag, exec_valid, fetch_addr, exec_pc, exec_word,
                  m_val, m_pc, m_epc, mem_word(m_epc));
      end
   endtask

   task automatic step(input bit j, input bit c, input bit r, input bit i,
                       input logic [8:0] off, input logic [8:0] vec, input string tag);
      do_jump = j; do_call = c; do_return = r; do_irq = i;
      rel_off = off; irq_vec = vec;
      if (m_val && (j | c | r | i)) begin
         if (i) begin
            m_push(m_epc);
            m_pc = vec;
         end else if (r) begin
            m_pc = m_stk[0];
            m_stk[0] = m_stk[1];
            m_stk[1] = m_stk[2];
         end else if (c) begin
            m_push(m_epc + 9'd1);
            m_pc = m_epc + 9'd1 + off;
         end else begin
            m_pc = m_epc + 9'd1 + off;
         end
         m_val = 1'b0;
      end else begin
         m_epc = m_pc;
         m_val = 1'b1;
         m_pc  = m_pc + 9'd1;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag);
      do_jump = 0; do_call = 0; do_return = 0; do_irq = 0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, '0, '0, tag);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      idle(1, "R1 first fetch");

      // R10: return with nothing pushed yields the reset bottom value 0
      step(0, 0, 1, 0, '0, '0, "R10 empty pop");
      idle(2, "R10 refill");
      step(0, 0, 1, 0, '0, '0, "R10 empty pop again");
      idle(2, "R10 refill");

      idle(600, "R2 sequential wrap");

      for (int k = 0; k < 512; k++) begin
         step(1, 0, 0, 0, 9'(k), '0, "R3 jump offset");
         step(0, 0, 0, 0, '0, '0, "R8 bubble");
         step(0, 0, 0, 0, '0, '0, "R3 target executes");
      end

      for (int k = 0; k < 4; k++) begin
         step(0, 1, 0, 0, 9'(37 + 61 * k), '0, "R4 call");
         idle(2, "R4 refill");
      end
      for (int k = 0; k < 5; k++) begin
         step(0, 0, 1, 0, '0, '0, "R9 return order");
         idle(2, "R5 refill");
      end

      step(0, 0, 0, 1, '0, 9'h1F0, "R6 irq entry");
      idle(3, "R6 handler");
      step(0, 0, 1, 0, '0, '0, "R6 return to interrupted");
      idle(2, "R6 resume");

      for (int m = 1; m < 16; m++) begin
         step(m[0], m[1], m[2], m[3], 9'(3 * m + 200), 9'(17 * m), "R7 priority");
         idle(2, "R7 refill");
      end

      step(1, 0, 0, 0, 9'h0F0, '0, "R11 jump");
      step(0, 1, 0, 1, 9'h011, 9'h055, "R11 strobes in bubble ignored");
      idle(1, "R11 after bubble");
      step(0, 0, 1, 0, '0, '0, "R11 stack untouched");
      idle(2, "R11 refill");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule